// File: doc/BRIEF.md
# Treelet Queue Processor Binder

The binder decides which per-treelet ray queue each of a set of ray processors works on. It keeps a ray count for every queue, driven by enqueue and dequeue events, and a table of the queue each processor is currently bound to. When a processor reports that its input queue has run dry, the binder releases that binding, marks the processor as waiting and hands it a new queue. The goal is to change bindings as rarely as possible.

Two arbitration policies are selectable at run time. The lazy policy hands a waiting processor the queue holding the most rays, even if other processors already serve it. The balanced policy turns each queue's ray count into a processor request. It subtracts the processors already bound there and grants the queue with the largest remaining shortfall. A lookup port resolves a node index to its queue and reports the lowest-numbered processor already bound to that queue, so a ray crossing into that treelet can go straight to that processor instead of through memory. The queue storage itself lives outside this block.

Bind decisions leave on a valid/ready stream. Once `bind_valid` is high, `bind_proc` and `bind_qid` stay fixed until a cycle with `bind_ready` high consumes them. While the stream is stalled, no further decision is made. A binding is recorded in the table in the cycle its offer appears, so lookups see it at once. Count updates, empty events and lookups are plain control pins with no back-pressure.

Top module: `treelet_binder`

## Requirements
- R1: After reset every count is zero, no processor is bound or waiting, `bind_valid` is low and every lookup misses.
- R2: An enqueue takes its queue id from the top log2(N_QUEUE) bits of `enq_node` and adds one to that queue's count, which saturates at 2^CNT_W-1.
- R3: A dequeue subtracts one from the named queue's count and is ignored when the count is zero. An enqueue and a dequeue on the same queue in one cycle leave its count unchanged.
- R4: A pulse on bit p of `proc_empty` unbinds processor p in the next cycle, so lookups stop returning it, and marks it waiting.
- R5: With `policy` = 0 (lazy), a waiting processor is bound to the queue with the largest nonzero count, lowest index on ties, regardless of how many processors already serve that queue.
- R6: With `policy` = 1 (balanced), a queue's request is ceil(count / RAYS_PER_PROC) capped at N_PROC, and its need is request minus processors bound to it. The queue with the largest positive need wins, lowest index on ties.
- R7: A queue with zero rays, or with no positive need under the balanced policy, is never granted. A waiting processor with no eligible queue stays waiting and is bound as soon as an update makes a queue eligible.
- R8: When several processors are waiting, the lowest-numbered one is served first, and one binding is issued per accepted offer.
- R9: While `bind_valid` is high and `bind_ready` is low, `bind_valid`, `bind_proc` and `bind_qid` hold. The offered binding is already visible to lookups.
- R10: The lookup is combinational. `route_hit` is high when some processor is bound to the queue in the top bits of `route_node`, and `route_proc` is the lowest such processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 1 | 0 lazy, 1 balanced |
| enq_valid | input | 1 | One ray was added to a queue this cycle |
| enq_node | input | NODE_W | Node index of the enqueued ray; top bits give the queue |
| deq_valid | input | 1 | One ray was removed from a queue this cycle |
| deq_qid | input | log2(N_QUEUE) | Queue losing a ray |
| proc_empty | input | N_PROC | One-cycle pulses: that processor's queue ran dry |
| bind_valid | output | 1 | A binding decision is offered |
| bind_ready | input | 1 | Consumer accepts the offered binding |
| bind_proc | output | log2(N_PROC) | Processor being bound |
| bind_qid | output | log2(N_QUEUE) | Queue it is bound to |
| route_node | input | NODE_W | Node index of a ray entering a treelet |
| route_hit | output | 1 | Target queue is served by some processor |
| route_proc | output | log2(N_PROC) | Lowest processor bound to the target queue |

## Verification
The bench aims at tie cases between equal counts and equal needs. A design that broke ties upward or kept the first queue with a lower score would name the wrong queue. It drives a waiting processor while every count is zero, then enqueues. A design that granted an empty queue would bind too early, and one that forgot the waiting processor would never bind. It pushes a count past saturation and dequeues at zero. Wrapping or underflow would then make a queue look fullest when it is not. It also stalls the bind stream and releases processors under both policies. A design that let the offer drift, or counted bound processors wrongly in the balanced need, would misplace later bindings.

// File: rtl/treelet_binder_pkg.sv
package treelet_binder_pkg;
  typedef enum logic {
    POL_LAZY     = 1'b0,
    POL_BALANCED = 1'b1
  } bind_policy_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/binder_count_bank.sv
module binder_count_bank #(
  parameter int N_QUEUE = 8,
  parameter int CNT_W   = 8,
  localparam int QID_W  = $clog2(N_QUEUE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [QID_W-1:0] enq_qid,
  input  logic             deq_valid,
  input  logic [QID_W-1:0] deq_qid,
  output logic [CNT_W-1:0] cnt [N_QUEUE]
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [N_QUEUE-1:0] inc;
  logic [N_QUEUE-1:0] dec;

  always_comb begin
    for (int q = 0; q < N_QUEUE; q++) begin
      inc[q] = enq_valid && (enq_qid == QID_W'(q));
      dec[q] = deq_valid && (deq_qid == QID_W'(q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < N_QUEUE; q++) cnt[q] <= '0;
    end else begin
      for (int q = 0; q < N_QUEUE; q++) begin
        if (inc[q] && !dec[q] && cnt[q] != CNT_MAX) cnt[q] <= cnt[q] + 1'b1;
        else if (dec[q] && !inc[q] && cnt[q] != '0) cnt[q] <= cnt[q] - 1'b1;
      end
    end
  end

  generate
    for (genvar q = 0; q < N_QUEUE; q++) begin : g_chk
      // R3: a dequeue at zero leaves the count at zero
      p_deq_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec[q] && !inc[q] && cnt[q] == '0) |=> cnt[q] == '0);
      // R2: the count stops at its ceiling
      p_enq_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[q] && !dec[q] && cnt[q] == CNT_MAX) |=> cnt[q] == CNT_MAX);
      // R3: paired update keeps the count
      p_pair_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[q] && dec[q]) |=> $stable(cnt[q]));
    end
  endgenerate
endmodule

// File: rtl/binder_table.sv
module binder_table #(
  parameter int N_PROC  = 16,
  parameter int N_QUEUE = 8,
  localparam int QID_W  = $clog2(N_QUEUE),
  localparam int PID_W  = $clog2(N_PROC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] proc_empty,
  input  logic              commit,
  input  logic [PID_W-1:0]  commit_proc,
  input  logic [QID_W-1:0]  commit_qid,
  input  logic [QID_W-1:0]  look_qid,
  output logic [N_PROC-1:0] waiting,
  output logic [PID_W:0]    nbound [N_QUEUE],
  output logic              look_hit,
  output logic [PID_W-1:0]  look_proc
);
  logic [N_PROC-1:0] bound_v;
  logic [QID_W-1:0]  bound_q [N_PROC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_v <= '0;
      waiting <= '0;
      for (int p = 0; p < N_PROC; p++) bound_q[p] <= '0;
    end else begin
      for (int p = 0; p < N_PROC; p++) begin
        if (proc_empty[p]) begin
          bound_v[p] <= 1'b0;
          waiting[p] <= 1'b1;
        end else if (commit && commit_proc == PID_W'(p)) begin
          bound_v[p] <= 1'b1;
          bound_q[p] <= commit_qid;
          waiting[p] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int q = 0; q < N_QUEUE; q++) begin
      nbound[q] = '0;
      for (int p = 0; p < N_PROC; p++)
        if (bound_v[p] && bound_q[p] == QID_W'(q)) nbound[q] = nbound[q] + 1'b1;
    end
  end

  always_comb begin
    look_hit  = 1'b0;
    look_proc = '0;
    for (int p = N_PROC - 1; p >= 0; p--) begin
      if (bound_v[p] && bound_q[p] == look_qid) begin
        look_hit  = 1'b1;
        look_proc = PID_W'(p);
      end
    end
  end

  // R8: only a waiting processor is ever granted
  p_commit_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> waiting[commit_proc]);

  generate
    for (genvar p = 0; p < N_PROC; p++) begin : g_chk
      // R4: a released processor is out of the table next cycle
      p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        proc_empty[p] |=> (!bound_v[p] && waiting[p]));
      // R4: a waiting processor never appears bound
      p_wait_unbound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        waiting[p] |-> !bound_v[p]);
    end
  endgenerate
endmodule

// File: rtl/binder_pick.sv
module binder_pick
  import treelet_binder_pkg::*;
#(
  parameter int N_PROC        = 16,
  parameter int N_QUEUE       = 8,
  parameter int CNT_W         = 8,
  parameter int RAYS_PER_PROC = 4,
  localparam int QID_W = $clog2(N_QUEUE),
  localparam int PID_W = $clog2(N_PROC),
  localparam int SC_W  = int'(max_u(CNT_W, PID_W + 1)) + $clog2(RAYS_PER_PROC) + 1
) (
  input  logic             policy_sel,
  input  logic [CNT_W-1:0] cnt    [N_QUEUE],
  input  logic [PID_W:0]   nbound [N_QUEUE],
  output logic             found,
  output logic [QID_W-1:0] sel_qid
);
  logic [N_QUEUE-1:0] elig;
  logic [SC_W-1:0]    score [N_QUEUE];
  bind_policy_e       pol;

  assign pol = bind_policy_e'(policy_sel);

  generate
    for (genvar q = 0; q < N_QUEUE; q++) begin : g_score
      logic [SC_W-1:0] wide_cnt;
      logic [SC_W-1:0] ceil_req;
      logic [SC_W-1:0] req;
      logic [SC_W-1:0] nb;
      logic            el;
      logic [SC_W-1:0] sc;

      always_comb begin
        wide_cnt = SC_W'(cnt[q]);
        nb       = SC_W'(nbound[q]);
        ceil_req = (wide_cnt + SC_W'(RAYS_PER_PROC - 1)) / SC_W'(RAYS_PER_PROC);
        req      = (ceil_req > SC_W'(N_PROC)) ? SC_W'(N_PROC) : ceil_req;
        if (pol == POL_BALANCED) begin
          el = req > nb;
          sc = req - nb;
        end else begin
          el = cnt[q] != '0;
          sc = wide_cnt;
        end
      end

      assign elig[q]  = el;
      assign score[q] = sc;
    end
  endgenerate

  always_comb begin
    logic [SC_W-1:0] best;
    found   = 1'b0;
    sel_qid = '0;
    best    = '0;
    for (int q = 0; q < N_QUEUE; q++) begin
      if (elig[q] && (!found || score[q] > best)) begin
        found   = 1'b1;
        sel_qid = QID_W'(q);
        best    = score[q];
      end
    end
  end
endmodule

// File: rtl/treelet_binder.sv
module treelet_binder #(
  parameter int N_PROC        = 16,
  parameter int N_QUEUE       = 8,
  parameter int NODE_W        = 12,
  parameter int CNT_W         = 8,
  parameter int RAYS_PER_PROC = 4,
  localparam int QID_W = $clog2(N_QUEUE),
  localparam int PID_W = $clog2(N_PROC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              policy,
  input  logic              enq_valid,
  input  logic [NODE_W-1:0] enq_node,
  input  logic              deq_valid,
  input  logic [QID_W-1:0]  deq_qid,
  input  logic [N_PROC-1:0] proc_empty,
  output logic              bind_valid,
  input  logic              bind_ready,
  output logic [PID_W-1:0]  bind_proc,
  output logic [QID_W-1:0]  bind_qid,
  input  logic [NODE_W-1:0] route_node,
  output logic              route_hit,
  output logic [PID_W-1:0]  route_proc
);
  logic [CNT_W-1:0]  cnt    [N_QUEUE];
  logic [PID_W:0]    nbound [N_QUEUE];
  logic [N_PROC-1:0] waiting;
  logic              found;
  logic [QID_W-1:0]  sel_qid;
  logic              have_wait;
  logic [PID_W-1:0]  first_wait;
  logic              load;
  logic              out_v;
  logic [PID_W-1:0]  out_p;
  logic [QID_W-1:0]  out_q;

  binder_count_bank #(.N_QUEUE(N_QUEUE), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_qid   (enq_node[NODE_W-1 -: QID_W]),
    .deq_valid (deq_valid),
    .deq_qid   (deq_qid),
    .cnt       (cnt)
  );

  binder_table #(.N_PROC(N_PROC), .N_QUEUE(N_QUEUE)) u_tab (
    .clk         (clk),
    .rst_n       (rst_n),
    .proc_empty  (proc_empty),
    .commit      (load),
    .commit_proc (first_wait),
    .commit_qid  (sel_qid),
    .look_qid    (route_node[NODE_W-1 -: QID_W]),
    .waiting     (waiting),
    .nbound      (nbound),
    .look_hit    (route_hit),
    .look_proc   (route_proc)
  );

  binder_pick #(
    .N_PROC(N_PROC), .N_QUEUE(N_QUEUE), .CNT_W(CNT_W), .RAYS_PER_PROC(RAYS_PER_PROC)
  ) u_pick (
    .policy_sel (policy),
    .cnt        (cnt),
    .nbound     (nbound),
    .found      (found),
    .sel_qid    (sel_qid)
  );

  always_comb begin
    have_wait  = 1'b0;
    first_wait = '0;
    for (int p = N_PROC - 1; p >= 0; p--) begin
      if (waiting[p]) begin
        have_wait  = 1'b1;
        first_wait = PID_W'(p);
      end
    end
  end

  assign load = have_wait && found && (!out_v || bind_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_p <= '0;
      out_q <= '0;
    end else if (load) begin
      out_v <= 1'b1;
      out_p <= first_wait;
      out_q <= sel_qid;
    end else if (bind_ready) begin
      out_v <= 1'b0;
    end
  end

  assign bind_valid = out_v;
  assign bind_proc  = out_p;
  assign bind_qid   = out_q;

  // R9: a stalled offer holds its payload
  p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !bind_ready) |=> (out_v && $stable(out_p) && $stable(out_q)));
  // R7: the chosen queue always holds rays
  p_pick_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cnt[sel_qid] != '0);
  // R9: an offered processor is visible to lookups on its queue
  p_offer_in_table_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (nbound[out_q] != '0));
endmodule

// File: tb/sim_treelet_binder.sv
`timescale 1ns/1ps
module sim_treelet_binder;
  localparam int NP = 16, NQ = 8, NW = 12, CMAX = 255, DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy = 1'b0;
  logic enq_valid = 1'b0;
  logic [NW-1:0] enq_node = '0;
  logic deq_valid = 1'b0;
  logic [2:0] deq_qid = '0;
  logic [NP-1:0] proc_empty = '0;
  logic bind_valid;
  logic bind_ready = 1'b0;
  logic [3:0] bind_proc;
  logic [2:0] bind_qid;
  logic [NW-1:0] route_node = '0;
  logic route_hit;
  logic [3:0] route_proc;

  treelet_binder u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .enq_valid(enq_valid), .enq_node(enq_node),
    .deq_valid(deq_valid), .deq_qid(deq_qid),
    .proc_empty(proc_empty),
    .bind_valid(bind_valid), .bind_ready(bind_ready),
    .bind_proc(bind_proc), .bind_qid(bind_qid),
    .route_node(route_node), .route_hit(route_hit), .route_proc(route_proc)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_cnt [NQ];
  bit m_bv [NP];
  int m_bq [NP];
  bit m_wait [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] node_of(input int q);
    return {3'(q), 9'($urandom % 512)};
  endfunction

  function automatic void m_clear();
    for (int q = 0; q < NQ; q++) m_cnt[q] = 0;
    for (int p = 0; p < NP; p++) begin m_bv[p] = 0; m_bq[p] = 0; m_wait[p] = 0; end
  endfunction

  function automatic void m_pick(output bit fnd, output int qs);
    int best = 0;
    fnd = 0; qs = 0;
    for (int q = 0; q < NQ; q++) begin
      int nb = 0, req, sc;
      bit el;
      for (int p = 0; p < NP; p++) if (m_bv[p] && m_bq[p] == q) nb++;
      req = (m_cnt[q] + DIV - 1) / DIV;
      if (req > NP) req = NP;
      if (policy) begin el = req > nb; sc = req - nb; end
      else begin el = m_cnt[q] > 0; sc = m_cnt[q]; end
      if (el && (!fnd || sc > best)) begin fnd = 1; qs = q; best = sc; end
    end
  endfunction

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_clear();
  endtask

  task automatic do_enq(input int q, input int n);
    enq_valid = 1;
    for (int i = 0; i < n; i++) begin
      enq_node = node_of(q);
      @(negedge clk);
      if (m_cnt[q] < CMAX) m_cnt[q]++;
    end
    enq_valid = 0;
  endtask

  task automatic do_deq(input int q, input int n);
    deq_valid = 1; deq_qid = 3'(q);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (m_cnt[q] > 0) m_cnt[q]--;
    end
    deq_valid = 0;
  endtask

  task automatic do_pair(input int q);
    enq_valid = 1; enq_node = node_of(q);
    deq_valid = 1; deq_qid = 3'(q);
    @(negedge clk);
    enq_valid = 0; deq_valid = 0;
  endtask

  task automatic do_empty(input logic [NP-1:0] mask);
    proc_empty = mask;
    @(negedge clk);
    proc_empty = '0;
    for (int p = 0; p < NP; p++) if (mask[p]) begin m_bv[p] = 0; m_wait[p] = 1; end
  endtask

  task automatic chk_route(input int q, input string req);
    bit eh = 0;
    int ep = 0;
    for (int p = NP - 1; p >= 0; p--) if (m_bv[p] && m_bq[p] == q) begin eh = 1; ep = p; end
    route_node = node_of(q);
    #1;
    chk(route_hit == eh, req, route_hit, eh);
    if (eh) chk(route_proc == 4'(ep), req, route_proc, ep);
  endtask

  task automatic settle();
    for (int it = 0; it < 40; it++) begin
      int pp = -1, q, w = 0;
      bit f;
      for (int p = NP - 1; p >= 0; p--) if (m_wait[p]) pp = p;
      if (pp < 0) return;
      m_pick(f, q);
      if (!f) begin
        repeat (3) @(negedge clk);
        chk(bind_valid == 0, "R7 no eligible queue", bind_valid, 0);
        return;
      end
      while (!bind_valid && w < 6) begin @(negedge clk); w++; end
      chk(bind_valid == 1, "R7 waiting processor bound", bind_valid, 1);
      if (!bind_valid) return;
      chk(bind_proc == 4'(pp), "R8 lowest waiting first", bind_proc, pp);
      if (policy) chk(bind_qid == 3'(q), "R6 balanced pick", bind_qid, q);
      else        chk(bind_qid == 3'(q), "R5 lazy pick", bind_qid, q);
      m_bv[pp] = 1; m_bq[pp] = q; m_wait[pp] = 0;
      bind_ready = 1;
      @(negedge clk);
      bind_ready = 0;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd61907));
    m_clear();
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk(bind_valid == 0, "R1 no offer after reset", bind_valid, 0);
    for (int q = 0; q < NQ; q++) chk_route(q, "R1 lookup misses after reset");
    // R7: idle with all counts zero, then woken by an enqueue
    do_empty(16'h0001);
    settle();
    do_enq(3, 1);
    settle();
    chk(m_bq[0] == 3, "R2 queue id from node top bits", m_bq[0], 3);
    chk_route(3, "R10 lookup hit");
    chk_route(2, "R10 lookup miss");
    // R5: lazy shares the fullest queue, ties go low
    do_enq(5, 3);
    do_empty(16'h0006);
    settle();
    chk_route(5, "R5 many processors on one queue");
    do_enq(1, 3);
    do_empty(16'h0008);
    settle();
    // R4: release drops the processor from lookups
    do_empty(16'h0002);
    chk_route(5, "R4 released processor not returned");
    settle();
    // R3: dequeue at zero ignored
    do_deq(7, 3);
    do_enq(7, 2);
    do_pair(7);
    do_empty(16'h0010);
    settle();
    // R2: saturation
    do_enq(4, 300);
    do_deq(4, 1);
    do_enq(6, 254);
    do_empty(16'h0040);
    settle();
    chk(m_bq[6] == 4, "R2 saturated count", m_bq[6], 4);
    do_deq(4, 254);
    do_deq(6, 254);
    // R6: balanced directed
    do_reset();
    policy = 1;
    do_enq(0, 9);
    do_enq(1, 4);
    do_empty(16'h001F);
    settle();
    chk(m_wait[4] == 1, "R7 no positive need leaves processor waiting", m_wait[4], 1);
    do_enq(2, 1);
    settle();
    // R9: stalled offer
    policy = 0;
    do_empty(16'h0020);
    begin
      int w = 0;
      logic [3:0] sp;
      logic [2:0] sq;
      bit f;
      int q;
      m_pick(f, q);
      while (!bind_valid && w < 6) begin @(negedge clk); w++; end
      sp = bind_proc; sq = bind_qid;
      chk(bind_valid == 1 && sp == 4'd5 && sq == 3'(q), "R9 offer present", bind_qid, q);
      m_bv[5] = 1; m_bq[5] = q; m_wait[5] = 0;
      chk_route(q, "R9 offered binding visible to lookups");
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(bind_valid == 1 && bind_proc == sp && bind_qid == sq, "R9 offer stable under stall",
            bind_qid, sq);
      end
      bind_ready = 1;
      @(negedge clk);
      bind_ready = 0;
      chk(bind_valid == 0, "R9 offer consumed", bind_valid, 0);
    end
    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 10;
      case (r)
        0, 1, 2, 3: do_enq($urandom % NQ, 1 + $urandom % 4);
        4, 5:       do_deq($urandom % NQ, 1 + $urandom % 3);
        6:          do_empty(NP'(1) << ($urandom % NP) | NP'(1) << ($urandom % NP));
        7:          do_pair($urandom % NQ);
        8:          chk_route($urandom % NQ, "R10 random lookup");
        default:    begin policy = ~policy; @(negedge clk); end
      endcase
      settle();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule